// File: doc/BRIEF.md
# Cell Write Guard and Reproduction Tracker

This block polices the memory stores issued by one self-replicating program ("cell") and follows the life cycle of that cell's single offspring. Every store carries a cell-relative address. A byte store touches one address and a word store touches two. The block grants a store only when every touched address lies in the cell's own region, or in the daughter window that is open at that moment. Loads are never presented to the block, so they are never restricted.

A reproduction request asks for a daughter of a given size, taken from the accumulator. If the size is legal and no daughter is outstanding, the block asks an external allocator in the same cycle. The allocator answers with a base address or a refusal. A successful answer opens a write window of that base and size. The matching divide request closes the window and emits a single-cycle record of the daughter's base and size.

Misuse raises an error pulse and increments a saturating error counter by the number of faults found in that cycle. Misuse means an illegal size, a double allocation, a divide with nothing outstanding, or a refused store. All responses appear one clock after the request, except the allocator request, which is combinational.

Top module: `cell_write_guard`

## Requirements
- R1: After reset, every response pulse is low, `alloc_ptr`, `spawn_base`, `spawn_size` and `err_count` are zero, and `win_open` is low.
- R2: A store whose touched addresses all satisfy 0 <= addr < `cell_size` (address read as signed) gives `st_ok`=1, `st_bad`=0 one cycle later, with no error.
- R3: A store that touches an address below 0 or at or above `cell_size`, outside any open window, gives `st_bad`=1 and an error one cycle later.
- R4: An allocate with 10 <= `acc` <= 512 (signed) and no open window drives `mem_req`=1 and `mem_size`=`acc` in the same cycle. When `mem_ok`=1, the next cycle shows `alloc_ack`=1, `alloc_ptr`=`mem_base` and `win_open`=1.
- R5: When the allocator answers `mem_ok`=0, the acknowledge carries `alloc_ptr`=0, the window stays closed, and no error is counted.
- R6: An allocate with `acc` outside 10..512 is an error. It returns `alloc_ptr`=0, never raises `mem_req`, and opens no window.
- R7: An allocate while a window is open (and not closed by a divide in the same cycle) is an error. It returns `alloc_ptr`=0, raises no `mem_req`, and leaves the window unchanged.
- R8: While a window is open, stores to base through base+size-1 are granted, and a store to base+size is refused unless it lies in the own region.
- R9: A word store (`st_word`=1) touches addr and addr+1. It is granted only if both are permitted; each may be permitted by either region.
- R10: A divide with an open window gives `spawn_vld`=1 next cycle, with `spawn_base`/`spawn_size` equal to the daughter's base and size, and closes the window. These fields are zero when `spawn_vld` is low.
- R11: A divide with no open window is an error and emits no spawn record.
- R12: A store is judged against the window as it stood before that cycle's divide or allocate. When divide and allocate arrive together, the divide is applied first, so the allocate may then succeed.
- R13: `err_pulse` is high one cycle after any fault. `err_count` grows by the number of faults in that cycle (up to three) and saturates at its maximum, 65535 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_size | input | AW | Size of the cell's own region |
| acc | input | AW | Requested daughter size (signed) |
| alloc_req | input | 1 | Allocate request |
| div_req | input | 1 | Divide request |
| mem_req | output | 1 | Request to external allocator (combinational) |
| mem_size | output | AW | Size asked from allocator, zero when idle |
| mem_ok | input | 1 | Allocator grant, same cycle as `mem_req` |
| mem_base | input | AW | Daughter base from allocator |
| alloc_ack | output | 1 | Allocate answered |
| alloc_ptr | output | AW | Returned daughter address, zero on failure |
| win_open | output | 1 | Daughter window currently open |
| spawn_vld | output | 1 | Divide completed pulse |
| spawn_base | output | AW | Base of the divided daughter |
| spawn_size | output | AW | Size of the divided daughter |
| st_vld | input | 1 | Store request |
| st_word | input | 1 | Store is two bytes wide |
| st_addr | input | AW | Cell-relative store address (signed) |
| st_ok | output | 1 | Store granted |
| st_bad | output | 1 | Store refused |
| err_pulse | output | 1 | At least one fault in the previous cycle |
| err_count | output | ERR_W | Saturating fault count |

## Verification
Two kinds of event can fall into one cycle: a store, and a window change caused by a divide or an allocate. A divide and an allocate can also coincide. The bench provokes both. It stores inside a window in the cycle that closes it, and stores into a fresh base in the cycle that opens it. It also issues a divide together with a new legal allocate. A behavioural model applies the ordering rule: stores see the old window, and the divide comes before the allocate. The bench compares every output on every clock, so a wrong ordering shows up as a grant/refusal mismatch or a missing acknowledge. A long run in which all three faults fire in the same cycle tests the multi-fault increment and the saturation of the counter.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
  typedef enum logic {
    WIN_SHUT = 1'b0,
    WIN_LIVE = 1'b1
  } win_state_e;
endpackage

// File: rtl/cwg_range_chk.sv
// Decides whether one signed relative address is writable: inside the own
// region or inside the daughter window (when it is open).
module cwg_range_chk #(
  parameter int AW = 16
) (
  input  logic [AW:0]   addr,      // sign-extended address, bit AW is sign
  input  logic [AW-1:0] own_size,
  input  logic          win_live,
  input  logic [AW-1:0] win_base,  // signed base
  input  logic [AW-1:0] win_size,
  output logic          hit
);
  localparam int EW = AW + 2;

  logic signed [EW-1:0] a_x;
  logic signed [EW-1:0] own_hi;
  logic signed [EW-1:0] w_lo;
  logic signed [EW-1:0] w_hi;
  logic                 own_hit;
  logic                 win_hit;

  always_comb begin
    a_x     = {addr[AW], addr};
    own_hi  = {2'b00, own_size};
    w_lo    = {{2{win_base[AW-1]}}, win_base};
    w_hi    = w_lo + {2'b00, win_size};
    own_hit = !a_x[EW-1] && (a_x < own_hi);
    win_hit = win_live && (a_x >= w_lo) && (a_x < w_hi);
    hit     = own_hit || win_hit;
  end
endmodule

// File: rtl/cwg_repro.sv
// Daughter life cycle: divide is applied first, then allocate, within a cycle.
module cwg_repro
  import cwg_pkg::*;
#(
  parameter int AW     = 16,
  parameter int MIN_SZ = 10,
  parameter int MAX_SZ = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic          div_req,
  input  logic [AW-1:0] acc,
  input  logic          mem_ok,
  input  logic [AW-1:0] mem_base,
  output logic          mem_req,
  output logic [AW-1:0] mem_size,
  output logic          win_live,
  output logic [AW-1:0] win_base,
  output logic [AW-1:0] win_size,
  output logic          alloc_ack,
  output logic [AW-1:0] alloc_ptr,
  output logic          spawn_vld,
  output logic [AW-1:0] spawn_base,
  output logic [AW-1:0] spawn_size,
  output logic          alloc_err,
  output logic          div_err
);
  localparam logic signed [AW:0] SZ_LO = (AW+1)'(MIN_SZ);
  localparam logic signed [AW:0] SZ_HI = (AW+1)'(MAX_SZ);

  win_state_e    state_q, state_mid, state_d;
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] size_q, size_d;
  logic          win_en;
  logic          ack_q, ack_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          spv_q, spv_d;
  logic [AW-1:0] spb_q, spb_d;
  logic [AW-1:0] sps_q, sps_d;
  logic signed [AW:0] acc_x;
  logic          size_ok;

  // next-state logic
  always_comb begin
    acc_x   = {acc[AW-1], acc};
    size_ok = (acc_x >= SZ_LO) && (acc_x <= SZ_HI);

    // divide stage
    state_mid = state_q;
    div_err   = 1'b0;
    spv_d     = 1'b0;
    spb_d     = '0;
    sps_d     = '0;
    if (div_req) begin
      if (state_q == WIN_LIVE) begin
        spv_d     = 1'b1;
        spb_d     = base_q;
        sps_d     = size_q;
        state_mid = WIN_SHUT;
      end else begin
        div_err = 1'b1;
      end
    end

    // allocate stage, sees the window after the divide
    state_d   = state_mid;
    base_d    = base_q;
    size_d    = size_q;
    win_en    = 1'b0;
    mem_req   = 1'b0;
    alloc_err = 1'b0;
    ack_d     = alloc_req;
    ptr_d     = '0;
    if (alloc_req) begin
      if (!size_ok) begin
        alloc_err = 1'b1;
      end else if (state_mid == WIN_LIVE) begin
        alloc_err = 1'b1;
      end else begin
        mem_req = 1'b1;
        if (mem_ok) begin
          state_d = WIN_LIVE;
          win_en  = 1'b1;
          base_d  = mem_base;
          size_d  = acc;
          ptr_d   = mem_base;
        end
      end
    end
    mem_size = mem_req ? acc : '0;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_SHUT;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
    end else if (win_en) begin
      base_q <= base_d;
      size_q <= size_d;
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      ptr_q <= '0;
      spv_q <= 1'b0;
      spb_q <= '0;
      sps_q <= '0;
    end else begin
      ack_q <= ack_d;
      ptr_q <= ptr_d;
      spv_q <= spv_d;
      spb_q <= spb_d;
      sps_q <= sps_d;
    end
  end

  assign win_live   = (state_q == WIN_LIVE);
  assign win_base   = base_q;
  assign win_size   = size_q;
  assign alloc_ack  = ack_q;
  assign alloc_ptr  = ptr_q;
  assign spawn_vld  = spv_q;
  assign spawn_base = spb_q;
  assign spawn_size = sps_q;
endmodule

// File: rtl/cwg_err_cnt.sv
// Saturating fault counter with a multi-fault increment.
module cwg_err_cnt #(
  parameter int W  = 16,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  count,
  output logic          pulse
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum;
  logic         cnt_en;
  logic         pulse_q, pulse_d;

  always_comb begin
    sum     = {1'b0, cnt_q} + (W+1)'(inc);
    cnt_en  = |inc;
    cnt_d   = sum[W] ? '1 : sum[W-1:0];
    pulse_d = |inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign count = cnt_q;
  assign pulse = pulse_q;
endmodule

// File: rtl/cell_write_guard.sv
module cell_write_guard #(
  parameter int AW     = 16,
  parameter int MIN_SZ = 10,
  parameter int MAX_SZ = 512,
  parameter int ERR_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    cell_size,
  input  logic [AW-1:0]    acc,
  input  logic             alloc_req,
  input  logic             div_req,
  output logic             mem_req,
  output logic [AW-1:0]    mem_size,
  input  logic             mem_ok,
  input  logic [AW-1:0]    mem_base,
  output logic             alloc_ack,
  output logic [AW-1:0]    alloc_ptr,
  output logic             win_open,
  output logic             spawn_vld,
  output logic [AW-1:0]    spawn_base,
  output logic [AW-1:0]    spawn_size,
  input  logic             st_vld,
  input  logic             st_word,
  input  logic [AW-1:0]    st_addr,
  output logic             st_ok,
  output logic             st_bad,
  output logic             err_pulse,
  output logic [ERR_W-1:0] err_count
);
  localparam int NBYTE = 2;
  localparam int IW    = 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic          win_live;
  logic [AW-1:0] win_base;
  logic [AW-1:0] win_size;
  logic          alloc_err;
  logic          div_err;

  cwg_repro #(
    .AW     (AW),
    .MIN_SZ (MIN_SZ),
    .MAX_SZ (MAX_SZ)
  ) u_repro (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .alloc_req  (alloc_req),
    .div_req    (div_req),
    .acc        (acc),
    .mem_ok     (mem_ok),
    .mem_base   (mem_base),
    .mem_req    (mem_req),
    .mem_size   (mem_size),
    .win_live   (win_live),
    .win_base   (win_base),
    .win_size   (win_size),
    .alloc_ack  (alloc_ack),
    .alloc_ptr  (alloc_ptr),
    .spawn_vld  (spawn_vld),
    .spawn_base (spawn_base),
    .spawn_size (spawn_size),
    .alloc_err  (alloc_err),
    .div_err    (div_err)
  );

  // per-byte permission, judged on the registered (pre-update) window
  logic [AW:0]       addr_ext;
  logic [NBYTE-1:0]  byte_hit;
  assign addr_ext = {st_addr[AW-1], st_addr};

  for (genvar k = 0; k < NBYTE; k++) begin : g_byte
    logic [AW:0] b_addr;
    assign b_addr = addr_ext + (AW+1)'(k);
    cwg_range_chk #(.AW(AW)) u_rng (
      .addr     (b_addr),
      .own_size (cell_size),
      .win_live (win_live),
      .win_base (win_base),
      .win_size (win_size),
      .hit      (byte_hit[k])
    );
  end

  logic st_grant, st_err;
  logic st_ok_q, st_ok_d, st_bad_q, st_bad_d;

  always_comb begin
    st_grant = byte_hit[0] && (byte_hit[1] || !st_word);
    st_ok_d  = st_vld && st_grant;
    st_bad_d = st_vld && !st_grant;
    st_err   = st_bad_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_ok_q  <= 1'b0;
      st_bad_q <= 1'b0;
    end else begin
      st_ok_q  <= st_ok_d;
      st_bad_q <= st_bad_d;
    end
  end

  assign st_ok    = st_ok_q;
  assign st_bad   = st_bad_q;
  assign win_open = win_live;

  logic [IW-1:0] fault_cnt;
  assign fault_cnt = IW'(st_err) + IW'(alloc_err) + IW'(div_err);

  cwg_err_cnt #(
    .W  (ERR_W),
    .IW (IW)
  ) u_err (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (fault_cnt),
    .count (err_count),
    .pulse (err_pulse)
  );
endmodule

// File: rtl/cell_write_guard_chk.sv
module cell_write_guard_chk #(
  parameter int AW     = 16,
  parameter int MIN_SZ = 10,
  parameter int MAX_SZ = 512,
  parameter int EW     = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_vld,
  input logic          st_ok,
  input logic          st_bad,
  input logic          alloc_req,
  input logic          div_req,
  input logic [AW-1:0] acc,
  input logic          mem_req,
  input logic          win_open,
  input logic          spawn_vld,
  input logic          alloc_ack,
  input logic [AW-1:0] alloc_ptr,
  input logic          err_pulse,
  input logic [EW-1:0] err_count
);
  localparam logic signed [AW:0] LO = (AW+1)'(MIN_SZ);
  localparam logic signed [AW:0] HI = (AW+1)'(MAX_SZ);

  logic signed [AW:0] acc_x;
  logic               size_bad;
  assign acc_x    = {acc[AW-1], acc};
  assign size_bad = (acc_x < LO) || (acc_x > HI);

  AST_STORE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_ok && st_bad)); // R2
  AST_STORE_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    st_vld |=> (st_ok || st_bad)); // R3
  AST_STORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !st_vld |=> !(st_ok || st_bad)); // R3
  AST_BAD_SIZE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && size_bad) |-> !mem_req); // R6
  AST_DOUBLE_ALLOC_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && win_open && !div_req) |-> !mem_req); // R7
  AST_FAILED_ACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ack && !win_open) |-> (alloc_ptr == '0)); // R5
  AST_DIVIDE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (div_req && win_open && !alloc_req) |=> (spawn_vld && !win_open)); // R10
  AST_LONE_DIVIDE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (div_req && !win_open) |=> (err_pulse && !spawn_vld)); // R11
  AST_COUNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_count >= $past(err_count))); // R13
  AST_COUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |-> $stable(err_count)); // R13
endmodule

bind cell_write_guard cell_write_guard_chk #(
  .AW     (AW),
  .MIN_SZ (MIN_SZ),
  .MAX_SZ (MAX_SZ),
  .EW     (ERR_W)
) u_cwg_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .st_vld    (st_vld),
  .st_ok     (st_ok),
  .st_bad    (st_bad),
  .alloc_req (alloc_req),
  .div_req   (div_req),
  .acc       (acc),
  .mem_req   (mem_req),
  .win_open  (win_open),
  .spawn_vld (spawn_vld),
  .alloc_ack (alloc_ack),
  .alloc_ptr (alloc_ptr),
  .err_pulse (err_pulse),
  .err_count (err_count)
);

// File: tb/cell_write_guard_bench.sv
module cell_write_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 16;
  localparam int CNT_MAX    = 65535;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] cell_size, acc, mem_base, st_addr;
  logic          alloc_req, div_req, mem_ok, st_vld, st_word;
  logic          mem_req, alloc_ack, win_open, spawn_vld, st_ok, st_bad, err_pulse;
  logic [AW-1:0] mem_size, alloc_ptr, spawn_base, spawn_size;
  logic [15:0]   err_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  cell_write_guard u_cell_write_guard (
    .clk(clk), .rst_n(rst_n), .cell_size(cell_size), .acc(acc),
    .alloc_req(alloc_req), .div_req(div_req), .mem_req(mem_req),
    .mem_size(mem_size), .mem_ok(mem_ok), .mem_base(mem_base),
    .alloc_ack(alloc_ack), .alloc_ptr(alloc_ptr), .win_open(win_open),
    .spawn_vld(spawn_vld), .spawn_base(spawn_base), .spawn_size(spawn_size),
    .st_vld(st_vld), .st_word(st_word), .st_addr(st_addr), .st_ok(st_ok),
    .st_bad(st_bad), .err_pulse(err_pulse), .err_count(err_count)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state
  int n_cell;
  bit m_pend;
  int m_base, m_size, m_cnt;
  int c_acc, c_addr, c_mbase;
  bit c_al, c_dv, c_sv, c_sw, c_ok;
  // expectations
  bit e_req, e_ack, e_spv, e_stok, e_stbad, e_errp;
  int e_msz, e_ptr, e_spb, e_sps;

  function automatic bit permitted(int a);
    return ((a >= 0) && (a < n_cell)) ||
           (m_pend && (a >= m_base) && (a < m_base + m_size));
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int  errs = 0;
    bit  p;
    bit  g;
    // stores see the window as it stands now
    e_stok = 1'b0; e_stbad = 1'b0;
    if (c_sv) begin
      g = permitted(c_addr) && (!c_sw || permitted(c_addr + 1));
      e_stok = g; e_stbad = !g;
      if (!g) errs++;
    end
    // divide first
    p = m_pend;
    e_spv = 1'b0; e_spb = 0; e_sps = 0;
    if (c_dv) begin
      if (p) begin e_spv = 1'b1; e_spb = m_base; e_sps = m_size; p = 1'b0; end
      else errs++;
    end
    // then allocate
    e_ack = c_al; e_ptr = 0; e_req = 1'b0;
    if (c_al) begin
      if (c_acc < 10 || c_acc > 512) errs++;
      else if (p) errs++;
      else begin
        e_req = 1'b1;
        if (c_ok) begin p = 1'b1; m_base = c_mbase; m_size = c_acc; e_ptr = c_mbase; end
      end
    end
    e_msz  = e_req ? c_acc : 0;
    m_pend = p;
    e_errp = (errs != 0);
    m_cnt  = (m_cnt + errs > CNT_MAX) ? CNT_MAX : m_cnt + errs;
  endtask

  task automatic run(string tag);
    model_step();
    #1;
    chk(tag, "mem_req", mem_req, e_req);
    chk(tag, "mem_size", mem_size, e_msz);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "alloc_ack", alloc_ack, e_ack);
    chk(tag, "alloc_ptr", alloc_ptr, e_ptr);
    chk(tag, "win_open", win_open, m_pend);
    chk(tag, "spawn_vld", spawn_vld, e_spv);
    chk(tag, "spawn_base", spawn_base, e_spb);
    chk(tag, "spawn_size", spawn_size, e_sps);
    chk(tag, "st_ok", st_ok, e_stok);
    chk(tag, "st_bad", st_bad, e_stbad);
    chk(tag, "err_pulse", err_pulse, e_errp);
    chk(tag, "err_count", err_count, m_cnt);
  endtask

  // inputs are applied at a falling edge
  task automatic drive(bit al, bit dv, int ac, bit sv, bit sw, int sa,
                       bit ok, int base, string tag);
    c_al = al; c_dv = dv; c_acc = ac; c_sv = sv; c_sw = sw;
    c_addr = sa; c_ok = ok; c_mbase = base;
    alloc_req = al; div_req = dv; acc = 16'(ac);
    st_vld = sv; st_word = sw; st_addr = 16'(sa);
    mem_ok = ok; mem_base = 16'(base);
    run(tag);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    n_cell = 100; m_pend = 0; m_base = 0; m_size = 0; m_cnt = 0;
    rst_n = 1'b0; cell_size = 16'(n_cell);
    alloc_req = 0; div_req = 0; acc = '0; mem_ok = 0; mem_base = '0;
    st_vld = 0; st_word = 0; st_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "alloc_ack", alloc_ack, 0);
    chk("R1", "alloc_ptr", alloc_ptr, 0);
    chk("R1", "win_open", win_open, 0);
    chk("R1", "spawn", {spawn_vld, spawn_base, spawn_size}, 0);
    chk("R1", "store", {st_ok, st_bad}, 0);
    chk("R1", "err", {err_pulse, err_count}, 0);

    // R2 / R3 own region
    drive(0, 0, 0, 1, 0, 0,   0, 0, "R2_low_edge");
    drive(0, 0, 0, 1, 0, 99,  0, 0, "R2_high_edge");
    drive(0, 0, 0, 1, 1, 50,  0, 0, "R2_word_inside");
    drive(0, 0, 0, 1, 0, 100, 0, 0, "R3_past_end");
    drive(0, 0, 0, 1, 0, -1,  0, 0, "R3_negative");
    // R6 size limits, R5 allocator refusal
    drive(1, 0, 9,   0, 0, 0, 1, 200, "R6_too_small");
    drive(1, 0, 513, 0, 0, 0, 1, 200, "R6_too_big");
    drive(1, 0, -4,  0, 0, 0, 1, 200, "R6_negative");
    drive(1, 0, 50,  0, 0, 0, 0, 200, "R5_refused");
    // R4 successful allocate, R8 window, R9 word stores
    drive(1, 0, 20, 0, 0, 0,   1, 200, "R4_alloc");
    drive(0, 0, 0,  1, 0, 200, 0, 0, "R8_base");
    drive(0, 0, 0,  1, 0, 219, 0, 0, "R8_last");
    drive(0, 0, 0,  1, 0, 220, 0, 0, "R8_past_window");
    drive(0, 0, 0,  1, 1, 218, 0, 0, "R9_word_in_window");
    drive(0, 0, 0,  1, 1, 219, 0, 0, "R9_word_spills");
    drive(0, 0, 0,  1, 1, 99,  0, 0, "R9_word_own_end");
    drive(0, 0, 0,  1, 1, -1,  0, 0, "R9_word_negative");
    // R7 double allocate
    drive(1, 0, 30, 0, 0, 0, 1, 500, "R7_double");
    drive(0, 0, 0,  1, 0, 210, 0, 0, "R7_window_kept");
    // R12 store in the closing cycle, R10 spawn record
    drive(0, 1, 0, 1, 0, 205, 0, 0, "R12_store_on_divide");
    drive(0, 0, 0, 1, 0, 205, 0, 0, "R10_window_closed");
    // R11 lone divide
    drive(0, 1, 0, 0, 0, 0, 0, 0, "R11_lone_divide");
    // R12 store into a window opening in the same cycle
    drive(1, 0, 10, 1, 0, 300, 1, 300, "R12_store_on_alloc");
    drive(0, 0, 0,  1, 0, 309, 0, 0,   "R4_min_size_window");
    // R12 divide and allocate together, boundary size 512
    drive(1, 1, 512, 0, 0, 0, 1, 400, "R12_divide_then_alloc");
    drive(0, 0, 0,   1, 1, 910, 0, 0, "R8_large_window_end");
    drive(0, 1, 0,   0, 0, 0, 0, 0,   "R10_close_large");
    // R13 three faults per cycle up to saturation
    for (int i = 0; i < 21846; i++)
      drive(1, 1, 0, 1, 0, -5, 1, 0, "R13_saturate");
    drive(0, 0, 0, 1, 0, 150, 0, 0, "R13_hold_max");
    drive(0, 0, 0, 0, 0, 0, 0, 0, "R13_quiet");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule